// File: doc/BRIEF.md
# Gain Control Register with Conditional Write Lock

This block is a 16-bit gain and output control word with a single-select write port and a continuous read-back. The word holds the level and mute settings for the left and right output paths, plus a few mode bits. Several conditions force the word back to its power-on value and reject writes while they last.

There are two groups of conditions. The first group holds the whole word at its default. It contains the external reset pin, the power-down pin and a global "power down everything" control bit. The second group holds only the upper byte at its default while the lower byte stays writable. It contains the analog mix enable and the analog channel enable.

The read-back shows the default value in the locked bit positions from the same cycle that a lock appears. When every lock has gone, the word keeps its default value until software writes it again. Bit 14 and bit 4 are reserved. They are stored as 0 and always read back as 0.

Top module: `gainctl_lockreg`

## Requirements
- R1: While `rst` is high at a clock edge, the stored word returns to 16'h8868, and `rdata` reads 16'h8868 after that edge.
- R2: With no lock active, a clock edge with `wr_en` high stores `wdata` with the reserved bits (14 and 4) cleared. `rdata` shows the stored value after that edge.
- R3: While `ext_rst_n` is 0, `rdata` reads 16'h8868 in that same cycle and writes have no effect.
- R4: While `pwr_n` is 0, `rdata` reads 16'h8868 in that same cycle and writes have no effect.
- R5: While `pdn_all` is 1, `rdata` reads 16'h8868 in that same cycle and writes have no effect.
- R6: While `mix_en` or `chan_en` is 0 and no whole-word lock is active, `rdata[15:8]` reads 8'h88 and writes to bits 15:8 have no effect. Bits 7:0 still accept writes.
- R7: After a lock is released, the bits it covered keep their default value until the next write. The value held before the lock is not restored.
- R8: A write presented in the same cycle that a lock becomes active is discarded for the bits that lock covers.
- R9: `rdata[14]` and `rdata[4]` always read 0, whatever is written.
- R10: The field outputs decode `rdata` as follows: `left_mute`=bit 15, `left_level`=bits 13:8, `right_mute`=bit 7, `ramp_bypass`=bit 6, `swing_hi`=bit 5, `mix_level`=bits 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_n | input | 1 | External reset pin, active low, locks the whole word |
| pwr_n | input | 1 | Power-down pin, active low, locks the whole word |
| pdn_all | input | 1 | Global power-down control bit, locks the whole word when 1 |
| mix_en | input | 1 | Analog mix enable, locks the upper byte when 0 |
| chan_en | input | 1 | Analog channel enable, locks the upper byte when 0 |
| wr_en | input | 1 | Write select for this register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Effective register value |
| left_mute | output | 1 | Left path mute |
| left_level | output | 6 | Left path level code |
| right_mute | output | 1 | Right path mute |
| ramp_bypass | output | 1 | Apply level changes immediately |
| swing_hi | output | 1 | High output swing select |
| mix_level | output | 4 | Mix level code |

## Verification
The bench writes data patterns whose upper and lower bytes differ. This shows whether a lock wrongly reaches the lower lane and whether a lane keeps stale data. It also writes all-ones to expose reserved bits that leak through. Each whole-word lock source is applied separately, with a write attempted during the lock and the value checked after release. This separates a correct return to the default from a restore of the earlier value. Both upper-byte lock sources are tried with a lower-byte write during the lock, which tells a byte-split lock apart from a whole-word lock. Writes that arrive in the same cycle as a lock show whether the lock takes priority over the write.

// File: rtl/gainctl_lockreg_pkg.sv
package gainctl_lockreg_pkg;

    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int N_LANES = DATA_W / LANE_W;

    localparam logic [DATA_W-1:0] DEFAULT_WORD = 16'h8868;
    localparam logic [DATA_W-1:0] RSVD_BITS    = 16'h4010;
    localparam logic [DATA_W-1:0] KEEP_MASK    = ~RSVD_BITS;

    typedef struct packed {
        logic       left_mute;
        logic       rsvd_hi;
        logic [5:0] left_level;
        logic       right_mute;
        logic       ramp_bypass;
        logic       swing_hi;
        logic       rsvd_lo;
        logic [3:0] mix_level;
    } ctl_word_t;

    typedef struct packed {
        logic lock_all;
        logic lock_hi;
    } lock_t;

    function automatic logic [DATA_W-1:0] scrub(input logic [DATA_W-1:0] d);
        return d & KEEP_MASK;
    endfunction

endpackage

// File: rtl/gainctl_lock_eval.sv
module gainctl_lock_eval
    import gainctl_lockreg_pkg::*;
(
    input  logic  ext_rst_n,
    input  logic  pwr_n,
    input  logic  pdn_all,
    input  logic  mix_en,
    input  logic  chan_en,
    output lock_t locks
);
    logic whole;

    always_comb begin
        whole          = !ext_rst_n || !pwr_n || pdn_all;
        locks.lock_all = whole;
        locks.lock_hi  = whole || !mix_en || !chan_en;
    end
endmodule

// File: rtl/gainctl_byte_lane.sv
module gainctl_byte_lane #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    DEF  = '0,
    parameter logic [W-1:0]    KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lock,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rd
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || lock) begin
            q <= DEF;
        end else if (wr_en) begin
            q <= wdata & KEEP;
        end
    end

    // locked bits read as default in the cycle the lock appears
    always_comb rd = lock ? DEF : q;
endmodule

// File: rtl/gainctl_field_decode.sv
module gainctl_field_decode
    import gainctl_lockreg_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    output logic              left_mute,
    output logic [5:0]        left_level,
    output logic              right_mute,
    output logic              ramp_bypass,
    output logic              swing_hi,
    output logic [3:0]        mix_level
);
    ctl_word_t f;

    always_comb begin
        f           = ctl_word_t'(word);
        left_mute   = f.left_mute;
        left_level  = f.left_level;
        right_mute  = f.right_mute;
        ramp_bypass = f.ramp_bypass;
        swing_hi    = f.swing_hi;
        mix_level   = f.mix_level;
    end
endmodule

// File: rtl/gainctl_lockreg.sv
module gainctl_lockreg
    import gainctl_lockreg_pkg::*;
#(
    parameter int HI_LOCK_LANES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              pwr_n,
    input  logic              pdn_all,
    input  logic              mix_en,
    input  logic              chan_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              left_mute,
    output logic [5:0]        left_level,
    output logic              right_mute,
    output logic              ramp_bypass,
    output logic              swing_hi,
    output logic [3:0]        mix_level
);
    localparam int FIRST_HI = N_LANES - HI_LOCK_LANES;

    lock_t             locks;
    logic [DATA_W-1:0] wclean;

    gainctl_lock_eval u_lock (
        .ext_rst_n (ext_rst_n),
        .pwr_n     (pwr_n),
        .pdn_all   (pdn_all),
        .mix_en    (mix_en),
        .chan_en   (chan_en),
        .locks     (locks)
    );

    always_comb wclean = scrub(wdata);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic lane_lock;
        if (i >= FIRST_HI) begin : g_hi
            always_comb lane_lock = locks.lock_hi;
        end else begin : g_lo
            always_comb lane_lock = locks.lock_all;
        end

        gainctl_byte_lane #(
            .W    (LANE_W),
            .DEF  (DEFAULT_WORD[i*LANE_W +: LANE_W]),
            .KEEP (KEEP_MASK[i*LANE_W +: LANE_W])
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .lock  (lane_lock),
            .wr_en (wr_en),
            .wdata (wclean[i*LANE_W +: LANE_W]),
            .rd    (rdata[i*LANE_W +: LANE_W])
        );
    end

    gainctl_field_decode u_dec (
        .word        (rdata),
        .left_mute   (left_mute),
        .left_level  (left_level),
        .right_mute  (right_mute),
        .ramp_bypass (ramp_bypass),
        .swing_hi    (swing_hi),
        .mix_level   (mix_level)
    );
endmodule

// File: rtl/gainctl_lockreg_chk.sv
module gainctl_lockreg_chk (
    input logic        clk,
    input logic        rst,
    input logic        ext_rst_n,
    input logic        pwr_n,
    input logic        pdn_all,
    input logic        mix_en,
    input logic        chan_en,
    input logic        wr_en,
    input logic [15:0] wdata,
    input logic [15:0] rdata
);
    logic whole_lk, hi_lk;
    always_comb begin
        whole_lk = !ext_rst_n || !pwr_n || pdn_all;
        hi_lk    = whole_lk || !mix_en || !chan_en;
    end

    p_reset_default_r1: assert property (@(posedge clk)
        rst |=> rdata == 16'h8868);

    // R3, R4, R5
    p_whole_lock_r5: assert property (@(posedge clk) disable iff (rst)
        whole_lk |-> rdata == 16'h8868);

    p_hi_lock_r6: assert property (@(posedge clk) disable iff (rst)
        hi_lk |-> rdata[15:8] == 8'h88);

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && !hi_lk && !rst) && !hi_lk)
        |-> rdata == ($past(wdata) & 16'hBFEF));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!wr_en && !hi_lk && !rst) && !hi_lk)
        |-> rdata == $past(rdata));

    p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
        (rdata & 16'h4010) == 16'h0000);
endmodule

bind gainctl_lockreg gainctl_lockreg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_rst_n (ext_rst_n),
    .pwr_n     (pwr_n),
    .pdn_all   (pdn_all),
    .mix_en    (mix_en),
    .chan_en   (chan_en),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .rdata     (rdata)
);

// File: tb/gainctl_lockreg_bench.sv
module gainctl_lockreg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1, pwr_n = 1'b1, pdn_all = 1'b0;
    logic        mix_en = 1'b1, chan_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        left_mute, right_mute, ramp_bypass, swing_hi;
    logic [5:0]  left_level;
    logic [3:0]  mix_level;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gainctl_lockreg u_gainctl_lockreg (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .pwr_n(pwr_n),
        .pdn_all(pdn_all), .mix_en(mix_en), .chan_en(chan_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .left_mute(left_mute), .left_level(left_level),
        .right_mute(right_mute), .ramp_bypass(ramp_bypass),
        .swing_hi(swing_hi), .mix_level(mix_level)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset value", rdata, 16'h8868);
        check("R10 default fields",
              {left_mute, left_level, right_mute, ramp_bypass, swing_hi, mix_level},
              {1'b1, 6'h08, 1'b0, 1'b1, 1'b1, 4'h8});
    endtask

    task automatic t_write();
        wr(16'h1234);
        check("R2 write 1234", rdata, 16'h1224);
        wr(16'hA5C3);
        check("R2 write A5C3", rdata, 16'hA5C3);
        check("R10 fields A5C3",
              {left_mute, left_level, right_mute, ramp_bypass, swing_hi, mix_level},
              {1'b1, 6'h25, 1'b1, 1'b1, 1'b0, 4'h3});
        step();
        check("R7 hold without write", rdata, 16'hA5C3);
    endtask

    task automatic t_reserved();
        wr(16'hFFFF);
        check("R9 reserved bits zero", rdata, 16'hBFEF);
    endtask

    task automatic set_whole(input int k, input logic on);
        case (k)
            0: ext_rst_n = !on;
            1: pwr_n     = !on;
            default: pdn_all = on;
        endcase
    endtask

    task automatic t_whole_lock(input int k, input string req);
        wr(16'h1224);
        set_whole(k, 1'b1);
        #1;
        check({req, " same-cycle default"}, rdata, 16'h8868);
        @(negedge clk);
        wr(16'h3333);
        check({req, " write ignored"}, rdata, 16'h8868);
        set_whole(k, 1'b0);
        step();
        check({"R7 after release ", req}, rdata, 16'h8868);
        wr(16'h0102);
        check({req, " writable after release"}, rdata, 16'h0102);
    endtask

    task automatic t_hi_lock(input bit use_mix);
        wr(16'h1224);
        if (use_mix) mix_en = 1'b0; else chan_en = 1'b0;
        #1;
        check("R6 upper default", rdata, 16'h8824);
        @(negedge clk);
        wr(16'h7777);
        check("R6 lower writable upper locked", rdata, 16'h8867);
        mix_en = 1'b1; chan_en = 1'b1;
        step();
        check("R7 upper stays default", rdata, 16'h8867);
        wr(16'h0000);
        check("R6 upper writable after release", rdata, 16'h0000);
    endtask

    task automatic t_same_cycle();
        wr(16'h0000);
        wr_en = 1'b1; wdata = 16'h1111; pwr_n = 1'b0;
        step();
        wr_en = 1'b0; pwr_n = 1'b1;
        step();
        check("R8 write with whole lock", rdata, 16'h8868);
        wr(16'h0000);
        wr_en = 1'b1; wdata = 16'h1111; chan_en = 1'b0;
        step();
        wr_en = 1'b0; chan_en = 1'b1;
        step();
        check("R8 write with upper lock", rdata, 16'h8801);
    endtask

    task automatic t_rst_mid();
        wr(16'h0F0F);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 reset mid-run", rdata, 16'h8868);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_write();
        t_reserved();
        t_whole_lock(0, "R3");
        t_whole_lock(1, "R4");
        t_whole_lock(2, "R5");
        t_hi_lock(1'b1);
        t_hi_lock(1'b0);
        t_same_cycle();
        t_rst_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule